// File: doc/BRIEF.md
# Release-Consistency Memory Ordering Gate

This block sits between an in-order stream of memory operations and a memory port. Each request carries a class (ordinary load, ordinary store, acquire, release), an ID and an address. The gate decides, one request at a time and in arrival order, whether the request at the head of the stream may go to memory now. A request that may go is accepted and issued in the same handshake. A request that may not go is held by deasserting ready. The gate never reorders requests. It only stalls them.

Completions come back from memory carrying the ID, in any order. A small scoreboard records every issued operation that has not completed yet, with its class and address. Issue is always in order, so every scoreboard entry is older than the request being considered. The ordering rules therefore reduce to checks of which classes are still outstanding. Acquires act as barriers that block later work. Releases act as barriers that wait for earlier work. Ordinary accesses may pass each barrier on its open side.

Top module: `rc_order_gate`

## Requirements
- R1: After reset, iss_valid is 0, outstanding is 0 and req_ready is 1.
- R2: While any acquire is outstanding, req_ready is 0 for every request class.
- R3: A release (class code 3) is not accepted while any ordinary load (code 0) or store (code 1) is outstanding.
- R4: An acquire (code 2) or release is not accepted while any earlier acquire or release is outstanding.
- R5: An ordinary load or store is accepted while an earlier release is still outstanding, provided no other rule blocks it.
- R6: An acquire is accepted while earlier ordinary loads or stores are still outstanding, provided no other rule blocks it.
- R7: When DEPTH operations are outstanding, req_ready is 0.
- R8: A load whose address equals that of an outstanding store is not accepted. A load to a different address, or a store to the same address, is not held by this rule.
- R9: A request accepted at a clock edge appears on iss_valid, iss_cls, iss_id and iss_addr during the next cycle only. iss_valid is 0 in any cycle that does not follow an acceptance.
- R10: outstanding equals accepted operations minus completed ones. A completion for any outstanding ID frees its entry, whatever the completion order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present at the head of the stream |
| req_ready | output | 1 | Gate accepts and issues the request this cycle |
| req_cls | input | 2 | Class: 0 load, 1 store, 2 acquire, 3 release |
| req_id | input | IDW | Operation ID, unique among outstanding operations |
| req_addr | input | AW | Operation address |
| iss_valid | output | 1 | Registered issue strobe toward memory |
| iss_cls | output | 2 | Class of the issued operation |
| iss_id | output | IDW | ID of the issued operation |
| iss_addr | output | AW | Address of the issued operation |
| cpl_valid | input | 1 | Memory reports a completion |
| cpl_id | input | IDW | ID of the completed operation |
| outstanding | output | $clog2(DEPTH+1) | Number of issued, uncompleted operations |

## Verification
req_ready is combinational from the scoreboard registers and the current request. A check on it therefore refers to the state left by the previous edge. The bench drives a request at a falling edge and reads ready 1 ns later, before the rising edge. The issue fields are registered, so they are due in the cycle after the accepting edge. The bench samples them at the following falling edge. A completion applied at one edge changes outstanding and ready from the next cycle, and each test reads them only after that edge has passed.

// File: rtl/rc_pkg.sv
package rc_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_ACQ   = 2'd2,
    OP_REL   = 2'd3
  } op_cls_t;

  function automatic logic cls_is_sync(input op_cls_t c);
    return c == OP_ACQ || c == OP_REL;
  endfunction

endpackage

// File: rtl/rc_scoreboard.sv
module rc_scoreboard
  import rc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDW   = 4,
  parameter int AW    = 16,
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ins_en,
  input  op_cls_t         ins_cls,
  input  logic [IDW-1:0]  ins_id,
  input  logic [AW-1:0]   ins_addr,
  input  logic            cpl_en,
  input  logic [IDW-1:0]  cpl_id,
  input  logic [AW-1:0]   probe_addr,
  output logic            full,
  output logic            live_acq,
  output logic            live_sync,
  output logic            live_ord,
  output logic            store_hit,
  output logic [CNTW-1:0] count
);

  logic [DEPTH-1:0] ent_vld;
  op_cls_t          ent_cls  [DEPTH];
  logic [IDW-1:0]   ent_id   [DEPTH];
  logic [AW-1:0]    ent_addr [DEPTH];

  logic [DEPTH-1:0] hit_cpl, is_acq, is_sync, is_ord, is_st_hit;
  logic [IDXW-1:0]  free_idx;

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!ent_vld[i]) free_idx = IDXW'(i);
    end
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_ent
      assign hit_cpl[g]   = ent_vld[g] && cpl_en && (ent_id[g] == cpl_id);
      assign is_acq[g]    = ent_vld[g] && (ent_cls[g] == OP_ACQ);
      assign is_sync[g]   = ent_vld[g] && cls_is_sync(ent_cls[g]);
      assign is_ord[g]    = ent_vld[g] && !cls_is_sync(ent_cls[g]);
      assign is_st_hit[g] = ent_vld[g] && (ent_cls[g] == OP_STORE) &&
                            (ent_addr[g] == probe_addr);

      always_ff @(posedge clk) begin
        if (rst) begin
          ent_vld[g]  <= 1'b0;
          ent_cls[g]  <= OP_LOAD;
          ent_id[g]   <= '0;
          ent_addr[g] <= '0;
        end else if (ins_en && !full && free_idx == IDXW'(g)) begin
          ent_vld[g]  <= 1'b1;
          ent_cls[g]  <= ins_cls;
          ent_id[g]   <= ins_id;
          ent_addr[g] <= ins_addr;
        end else if (hit_cpl[g]) begin
          ent_vld[g]  <= 1'b0;
        end
      end
    end
  endgenerate

  assign full      = &ent_vld;
  assign live_acq  = |is_acq;
  assign live_sync = |is_sync;
  assign live_ord  = |is_ord;
  assign store_hit = |is_st_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      count <= count + CNTW'(ins_en && !full) - CNTW'(|hit_cpl);
    end
  end

endmodule

// File: rtl/rc_issue_rule.sv
module rc_issue_rule
  import rc_pkg::*;
(
  input  op_cls_t req_cls,
  input  logic    full,
  input  logic    live_acq,
  input  logic    live_sync,
  input  logic    live_ord,
  input  logic    store_hit,
  output logic    may_issue
);

  logic hold;

  always_comb begin
    hold = full || live_acq;
    unique case (req_cls)
      OP_LOAD:  hold = hold || store_hit;
      OP_STORE: hold = hold;
      OP_ACQ:   hold = hold || live_sync;
      OP_REL:   hold = hold || live_sync || live_ord;
    endcase
    may_issue = !hold;
  end

endmodule

// File: rtl/rc_order_gate.sv
module rc_order_gate
  import rc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDW   = 4,
  parameter int AW    = 16,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_cls,
  input  logic [IDW-1:0]  req_id,
  input  logic [AW-1:0]   req_addr,
  output logic            iss_valid,
  output logic [1:0]      iss_cls,
  output logic [IDW-1:0]  iss_id,
  output logic [AW-1:0]   iss_addr,
  input  logic            cpl_valid,
  input  logic [IDW-1:0]  cpl_id,
  output logic [CNTW-1:0] outstanding
);

  op_cls_t cls_in;
  logic    sb_full, sb_acq, sb_sync, sb_ord, sb_st_hit, fire;

  assign cls_in = op_cls_t'(req_cls);
  assign fire   = req_valid && req_ready;

  rc_scoreboard #(.DEPTH(DEPTH), .IDW(IDW), .AW(AW)) u_sb (
    .clk        (clk),
    .rst        (rst),
    .ins_en     (fire),
    .ins_cls    (cls_in),
    .ins_id     (req_id),
    .ins_addr   (req_addr),
    .cpl_en     (cpl_valid),
    .cpl_id     (cpl_id),
    .probe_addr (req_addr),
    .full       (sb_full),
    .live_acq   (sb_acq),
    .live_sync  (sb_sync),
    .live_ord   (sb_ord),
    .store_hit  (sb_st_hit),
    .count      (outstanding)
  );

  rc_issue_rule u_rule (
    .req_cls   (cls_in),
    .full      (sb_full),
    .live_acq  (sb_acq),
    .live_sync (sb_sync),
    .live_ord  (sb_ord),
    .store_hit (sb_st_hit),
    .may_issue (req_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid <= 1'b0;
      iss_cls   <= '0;
      iss_id    <= '0;
      iss_addr  <= '0;
    end else begin
      iss_valid <= fire;
      if (fire) begin
        iss_cls  <= req_cls;
        iss_id   <= req_id;
        iss_addr <= req_addr;
      end
    end
  end

endmodule

// File: rtl/rc_order_gate_chk.sv
module rc_order_gate_chk #(
  parameter int DEPTH = 8,
  parameter int IDW   = 4,
  parameter int AW    = 16,
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int NID  = 1 << IDW
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic [1:0]      req_cls,
  input logic [IDW-1:0]  req_id,
  input logic [AW-1:0]   req_addr,
  input logic            iss_valid,
  input logic [1:0]      iss_cls,
  input logic [IDW-1:0]  iss_id,
  input logic [AW-1:0]   iss_addr,
  input logic            cpl_valid,
  input logic [IDW-1:0]  cpl_id,
  input logic [CNTW-1:0] outstanding
);

  logic [NID-1:0] m_live;
  logic [1:0]     m_cls [NID];
  logic           m_acq, m_sync, m_ord, fire;

  assign fire = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_live <= '0;
      for (int i = 0; i < NID; i++) m_cls[i] <= '0;
    end else begin
      if (cpl_valid) m_live[cpl_id] <= 1'b0;
      if (fire) begin
        m_live[req_id] <= 1'b1;
        m_cls[req_id]  <= req_cls;
      end
    end
  end

  always_comb begin
    m_acq = 1'b0; m_sync = 1'b0; m_ord = 1'b0;
    for (int i = 0; i < NID; i++) begin
      if (m_live[i] && m_cls[i] == 2'd2) m_acq = 1'b1;
      if (m_live[i] && m_cls[i][1])      m_sync = 1'b1;
      if (m_live[i] && !m_cls[i][1])     m_ord = 1'b1;
    end
  end

  assert_acq_blocks_R2: assert property (@(posedge clk) disable iff (rst)
    m_acq |-> !fire);
  assert_rel_waits_R3: assert property (@(posedge clk) disable iff (rst)
    (fire && req_cls == 2'd3) |-> !m_ord);
  assert_sync_order_R4: assert property (@(posedge clk) disable iff (rst)
    (fire && req_cls[1]) |-> !m_sync);
  assert_full_stall_R7: assert property (@(posedge clk) disable iff (rst)
    (outstanding == CNTW'(DEPTH)) |-> !req_ready);
  assert_issue_fields_R9: assert property (@(posedge clk) disable iff (rst)
    fire |=> (iss_valid && iss_id == $past(req_id) &&
              iss_cls == $past(req_cls) && iss_addr == $past(req_addr)));
  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (rst)
    !fire |=> !iss_valid);
  assert_count_match_R10: assert property (@(posedge clk) disable iff (rst)
    outstanding == CNTW'($countones(m_live)));

endmodule

bind rc_order_gate rc_order_gate_chk #(.DEPTH(DEPTH), .IDW(IDW), .AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_cls     (req_cls),
  .req_id      (req_id),
  .req_addr    (req_addr),
  .iss_valid   (iss_valid),
  .iss_cls     (iss_cls),
  .iss_id      (iss_id),
  .iss_addr    (iss_addr),
  .cpl_valid   (cpl_valid),
  .cpl_id      (cpl_id),
  .outstanding (outstanding)
);

// File: tb/rc_order_gate_bench.sv
`timescale 1ns/1ps
module rc_order_gate_bench;

  localparam int DEPTH = 8;
  localparam int IDW   = 4;
  localparam int AW    = 16;
  localparam int CNTW  = $clog2(DEPTH + 1);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [1:0]      req_cls = '0;
  logic [IDW-1:0]  req_id = '0;
  logic [AW-1:0]   req_addr = '0;
  logic            iss_valid;
  logic [1:0]      iss_cls;
  logic [IDW-1:0]  iss_id;
  logic [AW-1:0]   iss_addr;
  logic            cpl_valid = 1'b0;
  logic [IDW-1:0]  cpl_id = '0;
  logic [CNTW-1:0] outstanding;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rc_order_gate #(.DEPTH(DEPTH), .IDW(IDW), .AW(AW)) u_rc_order_gate (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_cls(req_cls), .req_id(req_id), .req_addr(req_addr),
    .iss_valid(iss_valid), .iss_cls(iss_cls), .iss_id(iss_id),
    .iss_addr(iss_addr), .cpl_valid(cpl_valid), .cpl_id(cpl_id),
    .outstanding(outstanding)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Present one request; expect it accepted (exp_rdy=1) or held (0).
  task automatic try_op(input int cls, input int id, input int addr,
                        input int exp_rdy, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_cls = 2'(cls); req_id = IDW'(id); req_addr = AW'(addr);
    #1;
    check(tag, "req_ready", int'(req_ready), exp_rdy);
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, "iss_valid", int'(iss_valid), exp_rdy);
    if (exp_rdy != 0) begin
      check("R9", "iss_id", int'(iss_id), id);
      check("R9", "iss_cls", int'(iss_cls), cls);
      check("R9", "iss_addr", int'(iss_addr), addr);
    end
  endtask

  task automatic complete(input int id);
    @(negedge clk);
    cpl_valid = 1'b1; cpl_id = IDW'(id);
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  task automatic check_count(input int exp, input string tag);
    @(negedge clk);
    check(tag, "outstanding", int'(outstanding), exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1", "iss_valid", int'(iss_valid), 0);
    check("R1", "outstanding", int'(outstanding), 0);
    check("R1", "req_ready", int'(req_ready), 1);
  endtask

  task automatic t_acquire;
    try_op(0, 1, 5, 1, "R6");
    try_op(2, 2, 0, 1, "R6");   // acquire passes outstanding load
    try_op(0, 3, 6, 0, "R2");
    try_op(1, 3, 6, 0, "R2");
    complete(2);
    try_op(0, 3, 6, 1, "R2");
    complete(1);
    complete(3);
    check_count(0, "R10");
  endtask

  task automatic t_release;
    try_op(1, 1, 2, 1, "R3");
    try_op(3, 2, 0, 0, "R3");
    complete(1);
    try_op(3, 2, 0, 1, "R3");
    try_op(0, 3, 7, 1, "R5");   // load passes outstanding release
    try_op(1, 4, 8, 1, "R5");
    complete(3);
    complete(4);
    complete(2);
    check_count(0, "R10");
  endtask

  task automatic t_sync_order;
    try_op(3, 4, 0, 1, "R4");
    try_op(2, 5, 0, 0, "R4");
    complete(4);
    try_op(2, 5, 0, 1, "R4");
    try_op(3, 6, 0, 0, "R4");
    complete(5);
    try_op(3, 6, 0, 1, "R4");
    complete(6);
    try_op(2, 7, 0, 1, "R4");
    try_op(2, 8, 0, 0, "R4");
    complete(7);
    try_op(2, 8, 0, 1, "R4");
    complete(8);
    check_count(0, "R10");
  endtask

  task automatic t_same_addr;
    try_op(1, 1, 9, 1, "R8");
    try_op(0, 2, 9, 0, "R8");
    try_op(0, 2, 3, 1, "R8");
    try_op(1, 3, 9, 1, "R8");
    complete(1);
    try_op(0, 4, 9, 0, "R8");
    complete(3);
    try_op(0, 4, 9, 1, "R8");
    complete(2);
    complete(4);
    check_count(0, "R10");
  endtask

  task automatic t_full;
    for (int i = 0; i < DEPTH; i++) try_op(0, i, 100 + i, 1, "R7");
    check_count(DEPTH, "R10");
    try_op(0, DEPTH, 200, 0, "R7");
    complete(3);
    check_count(DEPTH - 1, "R10");
    try_op(0, DEPTH, 200, 1, "R7");
    for (int i = 0; i <= DEPTH; i++) if (i != 3) complete(i);
    check_count(0, "R10");
  endtask

  task automatic t_pulse;
    try_op(1, 2, 11, 1, "R9");
    @(negedge clk);
    check("R9", "iss_valid after one cycle", int'(iss_valid), 0);
    complete(2);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_acquire();
    t_release();
    t_sync_order();
    t_same_addr();
    t_full();
    t_pulse();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule